// File: doc/BRIEF.md
# Split-Space Bus Decoder with Acknowledge Merge

This block is the glue between a CPU with a 20-bit address bus, an 8-bit data bus and an asynchronous strobe-and-acknowledge cycle, and two targets: a 512 KB static RAM that answers at once, and a slow memory-mapped I/O responder that answers when it is ready. The top address bit picks the target. While the active-low address strobe is low, the strobe is passed on as the enable of the target whose half of the space is being addressed. The other target stays idle.

The acknowledge returned to the CPU is also chosen by the top address bit. In the RAM half it is held asserted, so RAM cycles take no wait states. In the I/O half it copies the responder's own acknowledge. The RAM sees the low 19 address bits, and its write enable follows the CPU read/write line. Its output enable is held asserted. The I/O responder sees only the low 8 address bits, so its 256-byte window repeats across its whole half. By default the RAM occupies 0x80000–0xFFFFF and the I/O window occupies 0x00000–0x7FFFF. A parameter swaps the two halves.

All outputs are combinational. A two-bit region indicator shows which target, if any, is enabled at the moment.

Top module: `bus_glue`

## Requirements
- R1: While `asN` is 1, both `sramCeN` and `ioReqN` are 1, for any address.
- R2: While `asN` is 0 and the address lies in the I/O half, `ioReqN` is 0 and `sramCeN` is 1. With the default parameter, the I/O half is `addr[19]` = 0.
- R3: While `asN` is 0 and the address lies in the RAM half, `sramCeN` is 0 and `ioReqN` is 1. With the default parameter, the RAM half is `addr[19]` = 1.
- R4: While the address lies in the RAM half, `cpuAckN` is 0, whatever the values of `ioAckN` and `asN`.
- R5: While the address lies in the I/O half, `cpuAckN` equals `ioAckN`.
- R6: `sramWeN` equals `rwN` (1 = read, 0 = write), and `sramOeN` is always 0.
- R7: `sramAddr` equals `addr[18:0]` and `ioAddr` equals `addr[7:0]`, so the I/O window repeats every 256 bytes.
- R8: `regionSel` bit 0 marks the I/O target as enabled and bit 1 marks the RAM as enabled. At most one bit is set, and both bits are 0 while `asN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| asN | input | 1 | CPU address strobe, active low |
| addr | input | 20 | CPU address |
| rwN | input | 1 | CPU read/write line, 1 = read |
| ioAckN | input | 1 | I/O responder acknowledge, active low |
| sramCeN | output | 1 | RAM chip enable, active low |
| sramWeN | output | 1 | RAM write enable, active low |
| sramOeN | output | 1 | RAM output enable, held low |
| sramAddr | output | 19 | RAM address |
| ioReqN | output | 1 | I/O responder request, active low |
| ioAddr | output | 8 | I/O responder address |
| cpuAckN | output | 1 | Acknowledge to the CPU, active low |
| regionSel | output | 2 | Enabled target: bit 0 I/O, bit 1 RAM |

## Verification
Two functions can fall in the same cycle: routing the strobe to one target, and merging the acknowledge from the other. The slow responder may still hold its acknowledge low, or drop it, while the CPU has already moved to a RAM address. The bench provokes this by drawing `ioAckN` at random and independently of the strobe and address, and by adding directed cases where a stale I/O acknowledge meets a RAM cycle or a strobe-high cycle. Each case is judged against bench functions. Those functions require the RAM half to be acknowledged regardless of `ioAckN`, and the enables to depend only on strobe and half.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;

  // Strobes from the decode control to the datapath.
  typedef struct packed {
    logic selSram;   // RAM target enabled this instant
    logic selIo;     // I/O target enabled this instant
    logic sramHalf;  // address lies in RAM half (strobe independent)
  } ctlStrobes_t;

  localparam int unsigned REGION_IO_BIT   = 0;
  localparam int unsigned REGION_SRAM_BIT = 1;

endpackage

// File: rtl/bus_glue_ctl.sv
module bus_glue_ctl
  import bus_glue_pkg::*;
#(
  parameter bit SRAM_IN_UPPER = 1'b1
) (
  input  logic        asN,
  input  logic        topBit,
  output ctlStrobes_t ctl
);

  logic inSramHalf;
  logic strobeLive;

  assign strobeLive = ~asN;

  generate
    if (SRAM_IN_UPPER) begin : g_upper
      assign inSramHalf = topBit;
    end else begin : g_lower
      assign inSramHalf = ~topBit;
    end
  endgenerate

  always_comb begin
    ctl.sramHalf = inSramHalf;
    ctl.selSram  = strobeLive & inSramHalf;
    ctl.selIo    = strobeLive & ~inSramHalf;
  end

  always_comb begin
    // R8
    one_target_chk: assert ($onehot0({ctl.selSram, ctl.selIo}))
      else $error("both targets selected");
    // R1
    idle_no_select_chk: assert (!(asN && (ctl.selSram || ctl.selIo)))
      else $error("select while strobe idle");
  end

endmodule

// File: rtl/bus_glue_dp.sv
module bus_glue_dp
  import bus_glue_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned IO_AW   = 8,
  localparam int unsigned SRAM_AW = ADDR_W - 1
) (
  input  ctlStrobes_t        ctl,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rwN,
  input  logic               ioAckN,
  output logic               sramCeN,
  output logic               sramWeN,
  output logic               sramOeN,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic               ioReqN,
  output logic [IO_AW-1:0]   ioAddr,
  output logic               cpuAckN,
  output logic [1:0]         regionSel
);

  always_comb begin
    sramCeN  = ~ctl.selSram;
    ioReqN   = ~ctl.selIo;
    sramWeN  = rwN;
    sramOeN  = 1'b0;
    sramAddr = addr[SRAM_AW-1:0];
    ioAddr   = addr[IO_AW-1:0];
    cpuAckN  = ctl.sramHalf ? 1'b0 : ioAckN;
    regionSel = '0;
    regionSel[REGION_IO_BIT]   = ctl.selIo;
    regionSel[REGION_SRAM_BIT] = ctl.selSram;
  end

  always_comb begin
    // R2 R3
    enable_exclusive_chk: assert (sramCeN || ioReqN)
      else $error("both enables low");
    // R4
    sram_zero_wait_chk: assert (!(!sramCeN && cpuAckN))
      else $error("RAM cycle not acknowledged");
  end

endmodule

// File: rtl/bus_glue.sv
module bus_glue
  import bus_glue_pkg::*;
#(
  parameter int unsigned ADDR_W        = 20,
  parameter int unsigned IO_AW         = 8,
  parameter bit          SRAM_IN_UPPER = 1'b1
) (
  input  logic        asN,
  input  logic [19:0] addr,
  input  logic        rwN,
  input  logic        ioAckN,
  output logic        sramCeN,
  output logic        sramWeN,
  output logic        sramOeN,
  output logic [18:0] sramAddr,
  output logic        ioReqN,
  output logic [7:0]  ioAddr,
  output logic        cpuAckN,
  output logic [1:0]  regionSel
);

  ctlStrobes_t ctl;

  bus_glue_ctl #(.SRAM_IN_UPPER(SRAM_IN_UPPER)) u_ctl (
    .asN   (asN),
    .topBit(addr[ADDR_W-1]),
    .ctl   (ctl)
  );

  bus_glue_dp #(.ADDR_W(ADDR_W), .IO_AW(IO_AW)) u_dp (
    .ctl      (ctl),
    .addr     (addr),
    .rwN      (rwN),
    .ioAckN   (ioAckN),
    .sramCeN  (sramCeN),
    .sramWeN  (sramWeN),
    .sramOeN  (sramOeN),
    .sramAddr (sramAddr),
    .ioReqN   (ioReqN),
    .ioAddr   (ioAddr),
    .cpuAckN  (cpuAckN),
    .regionSel(regionSel)
  );

  always_comb begin
    // R5
    io_ack_pass_chk: assert (!(!ioReqN && (cpuAckN != ioAckN)))
      else $error("I/O acknowledge not passed through");
  end

endmodule

// File: tb/bus_glue_test.sv
module bus_glue_test;

  logic        clk = 1'b0;
  logic        asN, rwN, ioAckN;
  logic [19:0] addr;
  logic        sramCeN, sramWeN, sramOeN, ioReqN, cpuAckN;
  logic [18:0] sramAddr;
  logic [7:0]  ioAddr;
  logic [1:0]  regionSel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_glue uut (
    .asN(asN), .addr(addr), .rwN(rwN), .ioAckN(ioAckN),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .sramAddr(sramAddr), .ioReqN(ioReqN), .ioAddr(ioAddr),
    .cpuAckN(cpuAckN), .regionSel(regionSel)
  );

  function automatic logic expCe(logic s, logic [19:0] a);
    return !(!s && a[19]);
  endfunction
  function automatic logic expReq(logic s, logic [19:0] a);
    return !(!s && !a[19]);
  endfunction
  function automatic logic expAck(logic [19:0] a, logic k);
    return a[19] ? 1'b0 : k;
  endfunction
  function automatic logic [1:0] expSel(logic s, logic [19:0] a);
    return {!s && a[19], !s && !a[19]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (as=%b addr=%h ack=%b)",
               req, act, exp, asN, addr, ioAckN);
    end
  endtask

  task automatic apply(logic s, logic [19:0] a, logic rw, logic k);
    @(posedge clk);
    asN = s; addr = a; rwN = rw; ioAckN = k;
    @(negedge clk);
    if (s) begin
      chk("R1 ce", {31'b0, sramCeN}, 32'd1);
      chk("R1 req", {31'b0, ioReqN}, 32'd1);
    end else if (a[19]) begin
      chk("R3 ce", {31'b0, sramCeN}, {31'b0, expCe(s, a)});
      chk("R3 req", {31'b0, ioReqN}, {31'b0, expReq(s, a)});
    end else begin
      chk("R2 ce", {31'b0, sramCeN}, {31'b0, expCe(s, a)});
      chk("R2 req", {31'b0, ioReqN}, {31'b0, expReq(s, a)});
    end
    if (a[19]) chk("R4 ack", {31'b0, cpuAckN}, {31'b0, expAck(a, k)});
    else       chk("R5 ack", {31'b0, cpuAckN}, {31'b0, expAck(a, k)});
    chk("R6 we", {31'b0, sramWeN}, {31'b0, rw});
    chk("R6 oe", {31'b0, sramOeN}, 32'd0);
    chk("R7 sramAddr", {13'b0, sramAddr}, {13'b0, a[18:0]});
    chk("R7 ioAddr", {24'b0, ioAddr}, {24'b0, a[7:0]});
    chk("R8 sel", {30'b0, regionSel}, {30'b0, expSel(s, a)});
  endtask

  initial begin
    asN = 1'b1; addr = '0; rwN = 1'b1; ioAckN = 1'b1;
    @(negedge clk);
    // reset-like idle state
    chk("R1 idle ce", {31'b0, sramCeN}, 32'd1);
    chk("R1 idle req", {31'b0, ioReqN}, 32'd1);
    chk("R8 idle sel", {30'b0, regionSel}, 32'd0);

    // directed corners
    apply(1'b0, 20'h80000, 1'b1, 1'b1);  // R3 R4 lowest RAM address, responder idle
    apply(1'b0, 20'hFFFFF, 1'b0, 1'b0);  // R3 R6 top address, write
    apply(1'b0, 20'h7FFFF, 1'b1, 1'b1);  // R2 R5 top of I/O half, wait state
    apply(1'b0, 20'h7FFFF, 1'b1, 1'b0);  // R5 responder acknowledges
    apply(1'b0, 20'hC0000, 1'b1, 1'b0);  // R4 stale I/O ack meets RAM cycle
    apply(1'b1, 20'h80000, 1'b1, 1'b1);  // R1 R4 strobe idle, RAM half still acked
    apply(1'b1, 20'h00000, 1'b0, 1'b0);  // R1 strobe idle in I/O half
    apply(1'b0, 20'h00100, 1'b1, 1'b0);  // R7 mirror of window base
    apply(1'b0, 20'h123AB, 1'b0, 1'b1);  // R7 mirrored offset

    // random phase, fixed seed
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom();
      apply(r[0], r[31:12], r[1], r[2]);
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule